// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block prepares the second operand of a data-processing datapath. In shift mode it takes a 32-bit word and moves it by an amount taken either from a 5-bit field of the operand descriptor or from the low byte of a register value. It can shift left, shift right logically, shift right arithmetically or rotate right. It also produces the shifter carry that a later flag stage may adopt. In immediate-operand mode it ignores the word and builds a constant instead: an 8-bit field of the descriptor is rotated right by an even amount.

The block is purely combinational. Its outputs settle within the same cycle that the inputs are presented. Because no data is queued or held, there is no valid/ready pairing and no back-pressure. The caller samples `result` and `carry_out` in the cycle it supplies the operands. The operand descriptor `op_field` is 12 bits wide, and its layout depends on the mode. In shift mode, bits 11:7 hold the immediate amount and bits 6:5 hold the shift kind. In immediate-operand mode, bits 11:8 hold the rotate count and bits 7:0 hold the constant byte.

Top module: `barrel_shift_unit`

## Requirements
- R1: Shift kind is `op_field[6:5]`: 0 left-logical, 1 right-logical, 2 right-arithmetic, 3 rotate-right. For left-logical with amount n in 1..31, result is the word shifted left by n with zeros entering, and carry is word bit 32−n.
- R2: Right-logical with n in 1..31 gives the word shifted right by n with zeros entering, and carry is word bit n−1.
- R3: Right-arithmetic with n in 1..31 gives the word shifted right with copies of bit 31 entering, and carry is word bit n−1.
- R4: Rotate-right with n in 1..31 gives the word rotated right by n, and carry is word bit n−1.
- R5: With amount zero from either source, left-logical and right-arithmetic return the word unchanged with carry equal to `carry_in`.
- R6: With amount zero from either source, right-logical returns the word unchanged with carry equal to word bit 31.
- R7: Rotate-right with an immediate amount of zero shifts right by one through the carry. `carry_in` enters at bit 31, and old bit 0 becomes the carry.
- R8: Rotate-right with a register amount of zero returns the word and `carry_in` unchanged.
- R9: Right-arithmetic with a register amount of 32 or more gives all bits equal to word bit 31, and carry equal to word bit 31.
- R10: Logical shifts with a register amount of 32 or more give zero. At exactly 32 the carry is bit 0 for left and bit 31 for right. Above 32 the carry is 0.
- R11: Rotate-right with a register amount of 32 or more uses the amount modulo 32. A non-zero multiple of 32 returns the word unchanged with carry equal to bit 31.
- R12: When `imm_operand` is 1, the result is `op_field[7:0]` zero-extended and rotated right by twice `op_field[11:8]`. The carry is `carry_in` when that count is zero and result bit 31 otherwise. `op_value`, `reg_amount` and `amt_from_reg` have no effect.
- R13: When `amt_from_reg` is 1, only `reg_amount[7:0]` sets the amount, and bits 31:8 and `op_field[11:7]` have no effect. When it is 0, `op_field[11:7]` sets the amount and `reg_amount` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_value | input | 32 | Word to be shifted in shift mode |
| op_field | input | 12 | Operand descriptor: amount and kind, or rotate count and byte |
| reg_amount | input | 32 | Register-supplied amount; only the low 8 bits count |
| amt_from_reg | input | 1 | 1: amount from `reg_amount`; 0: amount from `op_field[11:7]` |
| imm_operand | input | 1 | 1: build a rotated 8-bit constant instead of shifting |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted word or expanded constant |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench sweeps every shift kind over every immediate amount and every register amount from 0 to 255. It uses several words and both carry values, so each zero-amount rule, the 32 boundary and the region above it are all covered. A design that treated every zero amount alike would fail the through-carry rotate, the register-rotate pass-through or the bit-31 carry on a right-logical shift by zero. A design that let register amounts wrap modulo 32 for every kind would return non-zero logical results, or a non-saturated arithmetic result, at 32 and above. The sweep also checks that stray high register bits and the unused amount source leave the outputs untouched. The immediate-operand sweep covers all sixteen rotate counts, including the zero count, where the carry must not come from bit 31.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned FIELD_W    = 12;
  localparam int unsigned F_AMT_LSB  = 7;
  localparam int unsigned F_KIND_LSB = 5;
  localparam int unsigned F_ROT_LSB  = 8;
  localparam int unsigned F_BYTE_LSB = 0;
  localparam int unsigned ROT_W      = 4;
  localparam int unsigned BYTE_W     = 8;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic zero;      // amount is zero
    logic at_width;  // amount equals the word width
    logic over;      // amount exceeds the word width
  } amt_class_t;

endpackage

// File: rtl/bsu_rotator.sv
module bsu_rotator #(
  parameter int unsigned W    = 32,
  parameter bit          LEFT = 1'b0,
  localparam int unsigned LW  = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [LW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [LW+1];

  assign stage[0] = din;

  for (genvar s = 0; s < LW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    logic [W-1:0] moved;
    if (LEFT) begin : g_left
      assign moved = {stage[s][W-1-D:0], stage[s][W-1:W-D]};
    end else begin : g_right
      assign moved = {stage[s][D-1:0], stage[s][W-1:D]};
    end
    assign stage[s+1] = amt[s] ? moved : stage[s];
  end

  assign dout = stage[LW];

endmodule

// File: rtl/bsu_amount_decode.sv
module bsu_amount_decode import bsu_pkg::*; #(
  parameter int unsigned W         = 32,
  parameter int unsigned REG_IN_W  = 32,
  parameter int unsigned REG_SEL_W = 8,
  localparam int unsigned LW       = $clog2(W)
) (
  input  logic                from_reg,
  input  logic [LW-1:0]       imm_amt,
  input  logic [REG_IN_W-1:0] reg_amt,
  output amt_class_t          cls,
  output logic [LW-1:0]       low
);

  logic [REG_SEL_W-1:0] eff;
  logic                 unused_reg_hi;

  assign unused_reg_hi = ^reg_amt[REG_IN_W-1:REG_SEL_W];

  always_comb begin
    if (from_reg) eff = reg_amt[REG_SEL_W-1:0];
    else          eff = REG_SEL_W'(imm_amt);
  end

  assign cls.zero     = (eff == '0);
  assign cls.at_width = (int'(eff) == int'(W));
  assign cls.over     = (int'(eff) >  int'(W));
  assign low          = eff[LW-1:0];

  always_comb begin
    AST_AMT_CLASS_ONEHOT: assert ($onehot0({cls.zero, cls.at_width, cls.over}))
      else $error("amount classes overlap"); // R13
    if (!from_reg)
      AST_IMM_AMT_SMALL: assert (!cls.at_width && !cls.over)
        else $error("field amount classed as large"); // R13
  end

endmodule

// File: rtl/bsu_shift_core.sv
module bsu_shift_core import bsu_pkg::*; #(
  parameter int unsigned W  = 32,
  localparam int unsigned LW = $clog2(W),
  localparam int          WI = int'(W)
) (
  input  logic [W-1:0]  value,
  input  shift_kind_e   kind,
  input  amt_class_t    cls,
  input  logic [LW-1:0] low,
  input  logic          from_reg,
  input  logic          carry_in,
  output logic [W-1:0]  shifted,
  output logic          carry_out
);

  logic [W-1:0] rol_v;
  logic [W-1:0] ror_v;
  logic [W-1:0] lmask;
  logic [W-1:0] rmask;
  logic         sign;
  logic         big;

  bsu_rotator #(.W(W), .LEFT(1'b1)) u_rol (.din(value), .amt(low), .dout(rol_v));
  bsu_rotator #(.W(W), .LEFT(1'b0)) u_ror (.din(value), .amt(low), .dout(ror_v));

  assign sign = value[W-1];
  assign big  = cls.at_width | cls.over;

  always_comb begin
    for (int i = 0; i < WI; i++) begin
      lmask[i] = (i >= int'(low));
      rmask[i] = ((i + int'(low)) < WI);
    end
  end

  always_comb begin
    shifted   = value;
    carry_out = carry_in;
    unique case (kind)
      SK_LSL: begin
        if (cls.zero) begin
          shifted   = value;
          carry_out = carry_in;
        end else if (!big) begin
          shifted   = rol_v & lmask;
          carry_out = rol_v[0];
        end else begin
          shifted   = '0;
          carry_out = cls.at_width & value[0];
        end
      end
      SK_LSR: begin
        if (cls.zero) begin
          shifted   = value;
          carry_out = sign;
        end else if (!big) begin
          shifted   = ror_v & rmask;
          carry_out = ror_v[W-1];
        end else begin
          shifted   = '0;
          carry_out = cls.at_width & sign;
        end
      end
      SK_ASR: begin
        if (cls.zero) begin
          shifted   = value;
          carry_out = carry_in;
        end else if (!big) begin
          shifted   = (ror_v & rmask) | (~rmask & {W{sign}});
          carry_out = ror_v[W-1];
        end else begin
          shifted   = {W{sign}};
          carry_out = sign;
        end
      end
      SK_ROR: begin
        if (cls.zero) begin
          if (from_reg) begin
            shifted   = value;
            carry_out = carry_in;
          end else begin
            shifted   = {carry_in, value[W-1:1]};
            carry_out = value[0];
          end
        end else begin
          shifted   = ror_v;
          carry_out = ror_v[W-1];
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    if (kind == SK_LSL && !cls.zero && !big)
      AST_LSL_LSB_CLEAR: assert (shifted[0] == 1'b0)
        else $error("left shift left bit 0 set"); // R1
    if (kind == SK_LSR && !cls.zero && !big)
      AST_LSR_MSB_CLEAR: assert (shifted[W-1] == 1'b0)
        else $error("right shift left bit msb set"); // R2
    if (kind == SK_ROR && !cls.zero)
      AST_ROR_KEEPS_ONES: assert ($countones(shifted) == $countones(value))
        else $error("rotate changed population"); // R4
    if (kind == SK_ASR && big)
      AST_ASR_SATURATE: assert (($countones(shifted) == 0 || $countones(shifted) == WI)
                                && carry_out == shifted[0])
        else $error("arithmetic saturation broken"); // R9
  end

endmodule

// File: rtl/bsu_imm_expand.sv
module bsu_imm_expand import bsu_pkg::*; #(
  parameter int unsigned W  = 32,
  localparam int unsigned LW = $clog2(W)
) (
  input  logic [BYTE_W-1:0] imm_byte,
  input  logic [ROT_W-1:0]  rot,
  output logic [W-1:0]      value,
  output logic              rot_zero
);

  logic [W-1:0]  widened;
  logic [LW-1:0] ramt;

  assign widened  = W'(imm_byte);
  assign ramt     = LW'({rot, 1'b0});
  assign rot_zero = (rot == '0);

  bsu_rotator #(.W(W), .LEFT(1'b0)) u_rot (.din(widened), .amt(ramt), .dout(value));

  always_comb begin
    AST_EXPAND_KEEPS_ONES: assert ($countones(value) == $countones(imm_byte))
      else $error("expansion changed population"); // R12
  end

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit import bsu_pkg::*; #(
  parameter int unsigned DATA_W    = WORD_W,
  parameter int unsigned REG_IN_W  = 32,
  parameter int unsigned REG_SEL_W = 8,
  localparam int unsigned LW       = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]   op_value,
  input  logic [FIELD_W-1:0]  op_field,
  input  logic [REG_IN_W-1:0] reg_amount,
  input  logic                amt_from_reg,
  input  logic                imm_operand,
  input  logic                carry_in,
  output logic [DATA_W-1:0]   result,
  output logic                carry_out
);

  shift_kind_e       kind;
  amt_class_t        cls;
  logic [LW-1:0]     low;
  logic [DATA_W-1:0] sh_val;
  logic              sh_carry;
  logic [DATA_W-1:0] imm_val;
  logic              rot_zero;

  assign kind = shift_kind_e'(op_field[F_KIND_LSB +: 2]);

  bsu_amount_decode #(
    .W(DATA_W), .REG_IN_W(REG_IN_W), .REG_SEL_W(REG_SEL_W)
  ) u_dec (
    .from_reg (amt_from_reg),
    .imm_amt  (op_field[F_AMT_LSB +: LW]),
    .reg_amt  (reg_amount),
    .cls      (cls),
    .low      (low)
  );

  bsu_shift_core #(.W(DATA_W)) u_core (
    .value     (op_value),
    .kind      (kind),
    .cls       (cls),
    .low       (low),
    .from_reg  (amt_from_reg),
    .carry_in  (carry_in),
    .shifted   (sh_val),
    .carry_out (sh_carry)
  );

  bsu_imm_expand #(.W(DATA_W)) u_imm (
    .imm_byte (op_field[F_BYTE_LSB +: BYTE_W]),
    .rot      (op_field[F_ROT_LSB +: ROT_W]),
    .value    (imm_val),
    .rot_zero (rot_zero)
  );

  always_comb begin
    if (imm_operand) begin
      result    = imm_val;
      carry_out = rot_zero ? carry_in : imm_val[DATA_W-1];
    end else begin
      result    = sh_val;
      carry_out = sh_carry;
    end
  end

  always_comb begin
    if (imm_operand && op_field[F_ROT_LSB +: ROT_W] == '0)
      AST_IMM_ROT0_PASS: assert (result[DATA_W-1:BYTE_W] == '0 && carry_out == carry_in)
        else $error("zero rotate immediate altered"); // R12
    if (!imm_operand && amt_from_reg && kind == SK_ROR && reg_amount[REG_SEL_W-1:0] == '0)
      AST_REG_ROR0_PASS: assert (result == op_value && carry_out == carry_in)
        else $error("register rotate by zero altered word"); // R8
    if (!imm_operand && (kind == SK_LSL || kind == SK_ASR) &&
        ((amt_from_reg && reg_amount[REG_SEL_W-1:0] == '0) ||
         (!amt_from_reg && op_field[F_AMT_LSB +: LW] == '0)))
      AST_ZERO_KEEPS_CARRY: assert (result == op_value && carry_out == carry_in)
        else $error("zero amount altered word or carry"); // R5
  end

endmodule

// File: tb/barrel_shift_unit_tb.sv
module barrel_shift_unit_tb;

  logic        clk = 1'b0;
  logic [31:0] op_value = '0;
  logic [11:0] op_field = '0;
  logic [31:0] reg_amount = '0;
  logic        amt_from_reg = 1'b0;
  logic        imm_operand = 1'b0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  barrel_shift_unit u_dut (
    .op_value, .op_field, .reg_amount, .amt_from_reg,
    .imm_operand, .carry_in, .result, .carry_out
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] er, input logic ec);
    checks++;
    if (result !== er || carry_out !== ec) begin
      errors++;
      $display("FAIL %s: actual result=%h carry=%b expected result=%h carry=%b",
               tag, result, carry_out, er, ec);
    end
  endtask

  task automatic ref_shift(input logic [31:0] v, input int k, input int n, input bit fr,
                           input bit ci, output logic [31:0] r, output logic c);
    logic [63:0] w;
    logic signed [63:0] sv;
    case (k)
      0: if (n == 0) begin r = v; c = ci; end
         else begin w = {32'h0, v} << n; r = w[31:0]; c = w[32]; end
      1: if (n == 0) begin r = v; c = v[31]; end
         else begin w = {v, 32'h0} >> n; r = w[63:32]; c = w[31]; end
      2: if (n == 0) begin r = v; c = ci; end
         else if (n >= 32) begin r = {32{v[31]}}; c = v[31]; end
         else begin sv = $signed({v, 32'h0}) >>> n; r = sv[63:32]; c = sv[31]; end
      default:
         if (n == 0) begin
           if (fr) begin r = v; c = ci; end
           else begin r = {ci, v[31:1]}; c = v[0]; end
         end else begin
           w = {v, v} >> (n % 32); r = w[31:0]; c = w[31];
         end
    endcase
  endtask

  function automatic string tag_of(input int k, input int n, input bit fr);
    if (n == 0) begin
      if (k == 0 || k == 2) return "R5";
      if (k == 1) return "R6";
      return fr ? "R8" : "R7";
    end
    if (n < 32) begin
      case (k)
        0: return "R1";
        1: return "R2";
        2: return "R3";
        default: return "R4";
      endcase
    end
    if (k == 2) return "R9";
    if (k == 3) return "R11";
    return "R10";
  endfunction

  logic [31:0] vals [6] = '{32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0000,
                            32'h7F3C_A5E1, 32'h9ABC_DEF0, 32'h0000_0080};
  logic [7:0]  bytes [8] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5, 8'h3C, 8'h7E, 8'hC1};

  initial begin
    logic [31:0] er;
    logic        ec;

    // All-zero inputs: left shift by zero, word 0, carry 0 (R5)
    #2;
    check("R5 idle", 32'h0, 1'b0);

    // Shift mode, every kind, every amount from both sources (R1..R11, R13)
    for (int vi = 0; vi < 6; vi++) begin
      for (int k = 0; k < 4; k++) begin
        for (int src = 0; src < 2; src++) begin
          for (int n = 0; n < (src != 0 ? 256 : 32); n++) begin
            for (int ci = 0; ci < 2; ci++) begin
              op_value     = vals[vi];
              imm_operand  = 1'b0;
              amt_from_reg = src[0];
              carry_in     = ci[0];
              if (src != 0) begin
                reg_amount = {24'hC3A55A, n[7:0]};
                op_field   = {5'd19, k[1:0], 5'b10110};
              end else begin
                reg_amount = 32'hDEAD_BEEF;
                op_field   = {n[4:0], k[1:0], 5'b01001};
              end
              #2;
              ref_shift(vals[vi], k, n, src[0], ci[0], er, ec);
              check(tag_of(k, n, src[0]), er, ec);
            end
          end
        end
      end
    end

    // High register bits vary, low byte decides (R13)
    for (int i = 0; i < 64; i++) begin
      automatic int n = (i * 37) % 256;
      automatic int k = i % 4;
      automatic logic [31:0] mix = i * 32'h9E37_79B1;
      op_value     = vals[i % 6] ^ mix;
      imm_operand  = 1'b0;
      amt_from_reg = 1'b1;
      carry_in     = i[0];
      reg_amount   = {mix[31:8] | 24'h1, n[7:0]};
      op_field     = {mix[4:0], k[1:0], 5'b0};
      #2;
      ref_shift(vals[i % 6] ^ mix, k, n, 1'b1, i[0], er, ec);
      check("R13 high bits", er, ec);
    end

    // Immediate-operand expansion over all rotate counts (R12)
    for (int b = 0; b < 8; b++) begin
      for (int rt = 0; rt < 16; rt++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [63:0] w;
          imm_operand  = 1'b1;
          op_value     = vals[(b + rt) % 6];
          reg_amount   = {rt[3:0], 28'h0} ^ 32'h0F0F_0F0F;
          amt_from_reg = rt[0];
          carry_in     = ci[0];
          op_field     = {rt[3:0], bytes[b]};
          #2;
          w  = {24'h0, bytes[b], 24'h0, bytes[b]} >> (2 * rt);
          er = w[31:0];
          ec = (rt == 0) ? ci[0] : er[31];
          check("R12 immediate", er, ec);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule